// File: doc/BRIEF.md
# Line Signal Quality Monitor

This block decides whether a received serial line is healthy enough to trust. A symbol decoder upstream pulses a one-cycle strobe whenever it sees an invalid symbol. The monitor splits time into fixed windows of reference clock cycles. At the end of each window it records whether any such strobe arrived during that window.

A saturating up/down quality counter integrates those per-window verdicts. The good-signal status only changes at the two ends of the counter's range, which gives hysteresis: a brief burst of errors does not drop a good line, and a brief clean spell does not raise a bad one.

A sticky change flag captures every status transition until software acknowledges it with a read strobe. An enable bit gates that flag onto an interrupt request line.

Top module: `lsq_monitor`

## Requirements
- R1: After reset the quality counter holds its top value 7, `goodSignal` is 0, `statusChanged` is 0 and `irqOut` is 0.
- R2: A window lasts exactly 1024 clock cycles, counted from the first rising edge after reset release. The window decision takes effect on every 1024th rising edge and at no other edge.
- R3: A window in which no bad-symbol strobe was seen lowers the quality counter by one, and the counter never goes below 0.
- R4: A window in which at least one bad-symbol strobe was seen raises the quality counter by one, and the counter never goes above 7.
- R5: `goodSignal` becomes 1 on the edge where the counter reaches 0 and becomes 0 on the edge where it reaches 7. For counter values 1 to 6 it keeps its previous value, so a status change needs at least seven consecutive windows of the same kind.
- R6: A strobe in the final cycle of a window counts toward that window. The record of bad symbols is cleared so that the following window starts clean.
- R7: `statusChanged` sets on the edge where `goodSignal` changes. It clears on the edge that samples `statusRead` high when no change occurs on that edge, and a change on that edge wins over the read.
- R8: `irqOut` equals `statusChanged` AND `irqEnable` at all times, with no register between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| badSymStrobe | input | 1 | One-cycle pulse per invalid received symbol |
| irqEnable | input | 1 | Enables the interrupt request |
| statusRead | input | 1 | Acknowledge strobe that clears the change flag |
| goodSignal | output | 1 | Line status, 1 = good, 0 = bad |
| statusChanged | output | 1 | Sticky flag, set on any status transition |
| irqOut | output | 1 | Interrupt request |

## Verification
A quality counter that steps wrongly, fails to saturate or wraps around shows up only through `goodSignal`. That evidence arrives late, at the window end where the status should or should not flip, which can be up to seven windows (about 7,200 cycles) after the fault. The bench therefore runs the counter into both limits and back again. It counts the exact number of windows needed for each flip, so a wrap below 0 or above 7 moves the flip by at least one window.

A window boundary placed at the wrong cycle moves the flip by whole cycles, so the first rise is also checked one cycle before the boundary. A bad-symbol record that is not cleared, or that drops a last-cycle strobe, changes the verdict of a window and shows at the next status decision.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  // Strobes from the window controller to the quality datapath
  typedef struct packed {
    logic windowEnd;   // last cycle of the current window
    logic windowBad;   // at least one bad symbol seen in this window
    logic readAck;     // status read strobe
  } lsqCtrl_t;

endpackage

// File: rtl/lsq_ctrl.sv
module lsq_ctrl
  import lsq_pkg::*;
#(
  parameter int WIN_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                badSymStrobe,
  input  logic                statusRead,
  output lsqCtrl_t            ctrl,
  output logic [WIN_BITS-1:0] winCount
);

  localparam logic [WIN_BITS-1:0] WIN_LAST = '1;

  logic badSeen;
  logic lastCycle;

  assign lastCycle = (winCount == WIN_LAST);

  // Free-running window counter; wraps at the window boundary
  always_ff @(posedge clk) begin
    if (!rstN) winCount <= '0;
    else       winCount <= winCount + 1'b1;
  end

  // Sticky bad-symbol record, cleared when the window closes
  always_ff @(posedge clk) begin
    if (!rstN)          badSeen <= 1'b0;
    else if (lastCycle) badSeen <= 1'b0;
    else if (badSymStrobe) badSeen <= 1'b1;
  end

  always_comb begin
    ctrl.windowEnd = lastCycle;
    // a strobe in the final cycle still belongs to this window
    ctrl.windowBad = badSeen | badSymStrobe;
    ctrl.readAck   = statusRead;
  end

endmodule

// File: rtl/lsq_datapath.sv
module lsq_datapath
  import lsq_pkg::*;
#(
  parameter int QMAX = 7,
  localparam int QW = $clog2(QMAX + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  lsqCtrl_t      ctrl,
  input  logic          irqEnable,
  output logic          goodSignal,
  output logic          statusChanged,
  output logic          irqOut,
  output logic [QW-1:0] qLevel
);

  localparam logic [QW-1:0] Q_TOP = QW'(QMAX);

  logic [QW-1:0] qNext;
  logic          goodNext;

  // Saturating up/down step, only at a window boundary
  always_comb begin
    qNext = qLevel;
    if (ctrl.windowEnd) begin
      if (ctrl.windowBad) begin
        if (qLevel != Q_TOP) qNext = qLevel + 1'b1;
      end else begin
        if (qLevel != '0) qNext = qLevel - 1'b1;
      end
    end
  end

  // Hysteresis: status flips only at the counter limits
  always_comb begin
    goodNext = goodSignal;
    if (qNext == '0)        goodNext = 1'b1;
    else if (qNext == Q_TOP) goodNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qLevel     <= Q_TOP;
      goodSignal <= 1'b0;
    end else begin
      qLevel     <= qNext;
      goodSignal <= goodNext;
    end
  end

  // Sticky change flag; a transition wins over a read
  always_ff @(posedge clk) begin
    if (!rstN)                       statusChanged <= 1'b0;
    else if (goodNext != goodSignal) statusChanged <= 1'b1;
    else if (ctrl.readAck)           statusChanged <= 1'b0;
  end

  assign irqOut = statusChanged & irqEnable;

endmodule

// File: rtl/lsq_monitor.sv
module lsq_monitor
  import lsq_pkg::*;
#(
  parameter int WIN_BITS = 10,
  parameter int QMAX     = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic badSymStrobe,
  input  logic irqEnable,
  input  logic statusRead,
  output logic goodSignal,
  output logic statusChanged,
  output logic irqOut
);

  localparam int QW = $clog2(QMAX + 1);

  lsqCtrl_t            ctrl;
  logic [WIN_BITS-1:0] winCount;
  logic [QW-1:0]       qLevel;

  lsq_ctrl #(.WIN_BITS(WIN_BITS)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .badSymStrobe (badSymStrobe),
    .statusRead   (statusRead),
    .ctrl         (ctrl),
    .winCount     (winCount)
  );

  lsq_datapath #(.QMAX(QMAX)) uData (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .irqEnable     (irqEnable),
    .goodSignal    (goodSignal),
    .statusChanged (statusChanged),
    .irqOut        (irqOut),
    .qLevel        (qLevel)
  );

endmodule

// File: rtl/lsq_monitor_chk.sv
module lsq_monitor_chk #(
  parameter int QMAX = 7,
  localparam int QW = $clog2(QMAX + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          windowEnd,
  input logic [QW-1:0] qLevel,
  input logic          goodSignal,
  input logic          statusChanged,
  input logic          irqEnable,
  input logic          irqOut
);

  localparam logic [QW-1:0] Q_TOP = QW'(QMAX);

  // R2: the quality level only moves at a window boundary
  a_r2_level_hold: assert property (@(posedge clk) disable iff (!rstN)
    !windowEnd |=> $stable(qLevel));

  // R2: boundaries are never back to back
  a_r2_spacing: assert property (@(posedge clk) disable iff (!rstN)
    windowEnd |=> !windowEnd);

  // R3, R4: one step at most per window
  a_r3_r4_single_step: assert property (@(posedge clk) disable iff (!rstN)
    windowEnd |=> (qLevel == $past(qLevel) || qLevel == $past(qLevel) + 1'b1
                   || qLevel == $past(qLevel) - 1'b1));

  // R5: status agrees with the counter at its limits
  a_r5_good_at_floor: assert property (@(posedge clk) disable iff (!rstN)
    (qLevel == '0) |-> goodSignal);

  a_r5_bad_at_top: assert property (@(posedge clk) disable iff (!rstN)
    (qLevel == Q_TOP) |-> !goodSignal);

  // R7: every status transition leaves the sticky flag set
  a_r7_flag_on_change: assert property (@(posedge clk) disable iff (!rstN)
    (goodSignal != $past(goodSignal)) |-> statusChanged);

  // R8: no request while disabled
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irqOut);

endmodule

bind lsq_monitor lsq_monitor_chk #(.QMAX(QMAX)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .windowEnd     (ctrl.windowEnd),
  .qLevel        (qLevel),
  .goodSignal    (goodSignal),
  .statusChanged (statusChanged),
  .irqEnable     (irqEnable),
  .irqOut        (irqOut)
);

// File: tb/sim_lsq_monitor.sv
module sim_lsq_monitor;

  localparam int WIN = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic badSymStrobe = 1'b0;
  logic irqEnable = 1'b0;
  logic statusRead = 1'b0;
  logic goodSignal, statusChanged, irqOut;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lsq_monitor u0 (
    .clk           (clk),
    .rstN          (rstN),
    .badSymStrobe  (badSymStrobe),
    .irqEnable     (irqEnable),
    .statusRead    (statusRead),
    .goodSignal    (goodSignal),
    .statusChanged (statusChanged),
    .irqOut        (irqOut)
  );

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // one rising edge; returns at the following falling edge
  task automatic tick();
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  // n cycles, strobe asserted in cycle strobeAt (-1 for none)
  task automatic runCycles(input int n, input int strobeAt);
    for (int i = 0; i < n; i++) begin
      badSymStrobe = (i == strobeAt);
      tick();
    end
    badSymStrobe = 1'b0;
  endtask

  task automatic runWindows(input int count, input int strobeAt);
    for (int w = 0; w < count; w++) runCycles(WIN, strobeAt);
  endtask

  task automatic align();
    while (cyc % WIN != 0) tick();
  endtask

  task automatic readPulse();
    statusRead = 1'b1;
    tick();
    statusRead = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc = 0;
    check("R1 goodSignal", goodSignal, 1'b0);
    check("R1 statusChanged", statusChanged, 1'b0);
    check("R1 irqOut", irqOut, 1'b0);
  endtask

  task automatic testFirstRise();
    runWindows(6, -1);
    check("R3/R5 six clean windows hold bad", goodSignal, 1'b0);
    runCycles(WIN - 1, -1);
    check("R2 one cycle before boundary", goodSignal, 1'b0);
    runCycles(1, -1);
    check("R2/R5 good at seventh boundary", goodSignal, 1'b1);
    check("R7 flag set on rise", statusChanged, 1'b1);
    check("R8 irq masked", irqOut, 1'b0);
  endtask

  task automatic testIrqAndRead();
    irqEnable = 1'b1;
    #1;
    check("R8 irq follows enable", irqOut, 1'b1);
    @(negedge clk);
    cyc++;
    readPulse();
    check("R7 read clears flag", statusChanged, 1'b0);
    check("R8 irq drops with flag", irqOut, 1'b0);
    align();
  endtask

  task automatic testHysteresis();
    runWindows(5, 500);
    runWindows(1, WIN - 1);
    check("R5/R6 level 6 still good", goodSignal, 1'b1);
    runWindows(1, -1);
    check("R6 record cleared, level 5 good", goodSignal, 1'b1);
    runWindows(2, WIN - 1);
    check("R4/R5/R6 bad at top", goodSignal, 1'b0);
    check("R7 flag set on fall", statusChanged, 1'b1);
    check("R8 irq raised", irqOut, 1'b1);
    readPulse();
    align();
  endtask

  task automatic testCeiling();
    runWindows(3, 0);
    runWindows(6, -1);
    check("R4 ceiling, level 1 still bad", goodSignal, 1'b0);
    check("R7 no spurious flag", statusChanged, 1'b0);
    runWindows(1, -1);
    check("R3 good after seven clean", goodSignal, 1'b1);
    readPulse();
    align();
  endtask

  task automatic testFloor();
    runWindows(4, -1);
    check("R3 floor keeps good", goodSignal, 1'b1);
    runWindows(6, 10);
    check("R3 floor, level 6 still good", goodSignal, 1'b1);
    runWindows(1, 10);
    check("R4/R5 bad after seven bad", goodSignal, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    testReset();
    testFirstRise();
    testIrqAndRead();
    testHysteresis();
    testCeiling();
    testFloor();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule